// File: doc/BRIEF.md
# Two-Dimensional DMA Word Address Sequencer

This block sequences the word addresses for one DMA channel moving a rectangular buffer. The buffer is a set of lines. Every line holds the same number of 32-bit words, and each line begins a fixed stride after the start of the line before it. The stride is the line length plus any gap, counted in words. Addresses are word addresses, which means a byte address shifted right by two.

Software loads the line length, stride, line count minus one, direction and burst-mode bit first, then presents the start address together with a one-cycle launch strobe. From then on the address moves forward only on cycles where the data handshake accepts a word.

A line length of zero selects ring mode. In ring mode the address walks a contiguous area of stride × (line count + 1) words and jumps back to the start address after the last word of the area. One pulse marks the completion of the first half of the area and another marks the second half, every time round. A stop input ends either mode at once.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, busy, done and both half pulses are low.
- R2: A launch strobe while idle and not stopping raises busy on the next cycle, with the address output equal to the presented start address. A launch strobe while busy has no effect on the running sequence.
- R3: With a non-zero line length L, a stride S and a line-count field N, the addresses are base + line×S + word, for line 0..N and word 0..L-1, in that order. A line-count field of 0 gives one line.
- R4: The address moves forward by exactly one position per accepted word and holds on every cycle without an accepted word.
- R5: In line mode, done is high for exactly one cycle, in the cycle after the last word of the last line is accepted. Busy falls in that same cycle.
- R6: A line length of 0 selects ring mode. Addresses run from base to base + S×(N+1) - 1 and then return to base. Ring mode never raises done.
- R7: In ring mode with area A, the first-half pulse is high in the cycle after the word at offset A/2-1 is accepted. The second-half pulse is high in the cycle after the word at offset A-1 is accepted. Both pulses repeat on every pass.
- R8: A stop input clears busy on the next cycle, with no done or half pulse. Stop takes priority over an accepted word and over a launch.
- R9: The direction output (1 = memory-to-device, 0 = device-to-memory) and the burst output (1 = 4-word bursts) take the input values at launch. They stay stable while busy, even if the inputs change.
- R10: Changes to the length, stride, line-count or base inputs while busy do not alter the running address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| launch_i | input | 1 | Start strobe; samples all parameters |
| stop_i | input | 1 | Abort the running sequence |
| base_i | input | ADDR_W | Start word address |
| line_len_i | input | LEN_W | Words per line; 0 selects ring mode |
| stride_i | input | LEN_W | Words from one line start to the next |
| last_line_i | input | LINES_W | Number of lines minus one |
| dir_i | input | 1 | Direction, 1 = memory-to-device |
| burst_i | input | 1 | 1 = 4-word bursts |
| beat_i | input | 1 | Data handshake accepts a word this cycle |
| addr_o | output | ADDR_W | Current word address |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| half_a_o | output | 1 | Ring first half complete |
| half_b_o | output | 1 | Ring second half complete |
| dir_o | output | 1 | Latched direction |
| burst_o | output | 1 | Latched burst mode |

## Verification
The assertions assume that reset is applied before the first launch. They also assume that a ring launch always describes an area of at least two words, so that the two half boundaries land on different offsets. They further assume that the handshake input is only meaningful while busy. The stimulus respects all three conditions. Every ring test uses a stride and line count whose product is even and at least two. Each test asserts reset before its first launch, and accepted words are only driven during a running sequence, apart from the deliberate stop-with-beat collision cases.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    typedef enum logic [0:0] {
        MODE_LINES = 1'b0,
        MODE_RING  = 1'b1
    } walk_mode_e;
endpackage

// File: rtl/dma2d_ring_span.sv
module dma2d_ring_span #(
    parameter int LEN_W   = 16,
    parameter int LINES_W = 16,
    localparam int AREA_W = LEN_W + LINES_W + 1
) (
    input  logic [LEN_W-1:0]   stride_i,
    input  logic [LINES_W-1:0] last_line_i,
    output logic [AREA_W-1:0]  area_m1_o,
    output logic [AREA_W-1:0]  half_m1_o
);
    logic [AREA_W-1:0] area;
    logic [AREA_W-1:0] half;

    always_comb begin
        area      = AREA_W'(stride_i) * (AREA_W'(last_line_i) + AREA_W'(1));
        half      = area >> 1;
        area_m1_o = area - AREA_W'(1);
        half_m1_o = half - AREA_W'(1);
    end
endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq
    import dma2d_pkg::*;
#(
    parameter int ADDR_W  = 30,
    parameter int LEN_W   = 16,
    parameter int LINES_W = 16,
    localparam int AREA_W = LEN_W + LINES_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch_i,
    input  logic               stop_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [LEN_W-1:0]   line_len_i,
    input  logic [LEN_W-1:0]   stride_i,
    input  logic [LINES_W-1:0] last_line_i,
    input  logic               dir_i,
    input  logic               burst_i,
    input  logic               beat_i,
    input  logic [AREA_W-1:0]  area_m1_i,
    input  logic [AREA_W-1:0]  half_m1_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               half_a_o,
    output logic               half_b_o,
    output logic               dir_o,
    output logic               burst_o
);
    typedef struct packed {
        logic               busy;
        walk_mode_e         mode;
        logic               done;
        logic               half_a;
        logic               half_b;
        logic               dir;
        logic               burst;
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  line_base;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   len;
        logic [LEN_W-1:0]   stride;
        logic [LEN_W-1:0]   word;
        logic [LINES_W-1:0] last;
        logic [LINES_W-1:0] line;
        logic [AREA_W-1:0]  area_m1;
        logic [AREA_W-1:0]  half_m1;
        logic [AREA_W-1:0]  off;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.half_a = 1'b0;
        st_d.half_b = 1'b0;
        if (stop_i) begin
            st_d.busy = 1'b0;
        end else if (!st_q.busy) begin
            if (launch_i) begin
                st_d.busy      = 1'b1;
                st_d.mode      = (line_len_i == '0) ? MODE_RING : MODE_LINES;
                st_d.dir       = dir_i;
                st_d.burst     = burst_i;
                st_d.base      = base_i;
                st_d.line_base = base_i;
                st_d.addr      = base_i;
                st_d.len       = line_len_i;
                st_d.stride    = stride_i;
                st_d.last      = last_line_i;
                st_d.word      = '0;
                st_d.line      = '0;
                st_d.area_m1   = area_m1_i;
                st_d.half_m1   = half_m1_i;
                st_d.off       = '0;
            end
        end else if (beat_i) begin
            if (st_q.mode == MODE_RING) begin
                if (st_q.off == st_q.area_m1) begin
                    st_d.off    = '0;
                    st_d.addr   = st_q.base;
                    st_d.half_b = 1'b1;
                end else begin
                    st_d.off    = st_q.off + AREA_W'(1);
                    st_d.addr   = st_q.addr + ADDR_W'(1);
                    st_d.half_a = (st_q.off == st_q.half_m1);
                end
            end else if (st_q.word == st_q.len - LEN_W'(1)) begin
                if (st_q.line == st_q.last) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.line_base = st_q.line_base + ADDR_W'(st_q.stride);
                    st_d.addr      = st_q.line_base + ADDR_W'(st_q.stride);
                    st_d.word      = '0;
                    st_d.line      = st_q.line + LINES_W'(1);
                end
            end else begin
                st_d.word = st_q.word + LEN_W'(1);
                st_d.addr = st_q.addr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o   = st_q.addr;
    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign half_a_o = st_q.half_a;
    assign half_b_o = st_q.half_b;
    assign dir_o    = st_q.dir;
    assign burst_o  = st_q.burst;
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
    parameter int ADDR_W  = 30,
    parameter int LEN_W   = 16,
    parameter int LINES_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch_i,
    input  logic               stop_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [LEN_W-1:0]   line_len_i,
    input  logic [LEN_W-1:0]   stride_i,
    input  logic [LINES_W-1:0] last_line_i,
    input  logic               dir_i,
    input  logic               burst_i,
    input  logic               beat_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               half_a_o,
    output logic               half_b_o,
    output logic               dir_o,
    output logic               burst_o
);
    localparam int AREA_W = LEN_W + LINES_W + 1;

    logic [AREA_W-1:0] area_m1;
    logic [AREA_W-1:0] half_m1;

    dma2d_ring_span #(
        .LEN_W   (LEN_W),
        .LINES_W (LINES_W)
    ) i_span (
        .stride_i    (stride_i),
        .last_line_i (last_line_i),
        .area_m1_o   (area_m1),
        .half_m1_o   (half_m1)
    );

    dma2d_seq #(
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W),
        .LINES_W (LINES_W)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch_i),
        .stop_i      (stop_i),
        .base_i      (base_i),
        .line_len_i  (line_len_i),
        .stride_i    (stride_i),
        .last_line_i (last_line_i),
        .dir_i       (dir_i),
        .burst_i     (burst_i),
        .beat_i      (beat_i),
        .area_m1_i   (area_m1),
        .half_m1_i   (half_m1),
        .addr_o      (addr_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .half_a_o    (half_a_o),
        .half_b_o    (half_b_o),
        .dir_o       (dir_o),
        .burst_o     (burst_o)
    );
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
    parameter int ADDR_W = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              launch_i,
    input logic              stop_i,
    input logic              beat_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              half_a_o,
    input logic              half_b_o,
    input logic              dir_o,
    input logic              burst_o
);
    p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!busy_o && !done_o && !half_a_o && !half_b_o));

    p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !beat_i && !stop_i) |=> (busy_o && $stable(addr_o)));

    p_pulses_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, half_a_o, half_b_o}));

    p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && launch_i && !stop_i) |=> busy_o);

    p_attr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(dir_o) && $stable(burst_o)));

    p_half_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (half_a_o || half_b_o) |-> busy_o);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch_i),
    .stop_i   (stop_i),
    .beat_i   (beat_i),
    .addr_o   (addr_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .half_a_o (half_a_o),
    .half_b_o (half_b_o),
    .dir_o    (dir_o),
    .burst_o  (burst_o)
);

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;
    localparam int ADDR_W  = 30;
    localparam int LEN_W   = 16;
    localparam int LINES_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic launch_i = 1'b0;
    logic stop_i = 1'b0;
    logic [ADDR_W-1:0] base_i = '0;
    logic [LEN_W-1:0] line_len_i = '0;
    logic [LEN_W-1:0] stride_i = '0;
    logic [LINES_W-1:0] last_line_i = '0;
    logic dir_i = 1'b0;
    logic burst_i = 1'b0;
    logic beat_i = 1'b0;
    logic [ADDR_W-1:0] addr_o;
    logic busy_o, done_o, half_a_o, half_b_o, dir_o, burst_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dma2d_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINES_W(LINES_W)) i_dma2d_addr_gen (
        .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .stop_i(stop_i),
        .base_i(base_i), .line_len_i(line_len_i), .stride_i(stride_i),
        .last_line_i(last_line_i), .dir_i(dir_i), .burst_i(burst_i),
        .beat_i(beat_i), .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o),
        .half_a_o(half_a_o), .half_b_o(half_b_o), .dir_o(dir_o), .burst_o(burst_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; launch_i = 1'b0; stop_i = 1'b0; beat_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic launch(input int base, input int len, input int stride,
                          input int last, input bit dir, input bit burst);
        base_i = ADDR_W'(base); line_len_i = LEN_W'(len);
        stride_i = LEN_W'(stride); last_line_i = LINES_W'(last);
        dir_i = dir; burst_i = burst; launch_i = 1'b1;
        @(negedge clk);
        launch_i = 1'b0;
    endtask

    // R1
    task automatic t_reset();
        do_reset();
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 halves", {half_a_o, half_b_o}, 0);
    endtask

    // R2 R3 R4 R5 R10: line walk with gaps, relaunch attempts and input changes
    task automatic t_lines();
        int base = 100, len = 3, stride = 5, last = 1;
        do_reset();
        launch(base, len, stride, last, 1'b0, 1'b0);
        chk("R2 busy after launch", busy_o, 1);
        chk("R2 first addr", addr_o, base);
        for (int ln = 0; ln <= last; ln++) begin
            for (int w = 0; w < len; w++) begin
                chk("R3 addr", addr_o, base + ln * stride + w);
                chk("R5 no early done", done_o, 0);
                if (w == 1) begin
                    beat_i = 1'b0;
                    launch_i = 1'b1;
                    base_i = 30'd7000; line_len_i = 16'd9; stride_i = 16'd40;
                    @(negedge clk);
                    launch_i = 1'b0;
                    chk("R4 hold addr", addr_o, base + ln * stride + w);
                    chk("R2 relaunch ignored", busy_o, 1);
                end
                beat_i = 1'b1;
                @(negedge clk);
            end
        end
        beat_i = 1'b0;
        chk("R5 done pulse", done_o, 1);
        chk("R5 busy fell", busy_o, 0);
        chk("R10 addr untouched by input changes", addr_o, base + last * stride + len - 1);
        @(negedge clk);
        chk("R5 done one cycle", done_o, 0);
    endtask

    // R3 R5: single line, single word
    task automatic t_single();
        do_reset();
        launch(4096, 1, 1, 0, 1'b0, 1'b0);
        chk("R3 single addr", addr_o, 4096);
        beat_i = 1'b1;
        @(negedge clk);
        beat_i = 1'b0;
        chk("R5 single done", done_o, 1);
        chk("R5 single idle", busy_o, 0);
    endtask

    // R6 R7: ring, area 8, two passes
    task automatic t_ring();
        int base = 200, area = 8;
        int na = 0, nb = 0, nd = 0;
        do_reset();
        launch(base, 0, 2, 3, 1'b0, 1'b0);
        for (int k = 0; k < 2 * area; k++) begin
            chk("R6 ring addr", addr_o, base + (k % area));
            beat_i = 1'b1;
            @(negedge clk);
            beat_i = 1'b0;
            chk("R7 half A timing", half_a_o, ((k % area) == area / 2 - 1) ? 1 : 0);
            chk("R7 half B timing", half_b_o, ((k % area) == area - 1) ? 1 : 0);
            na += half_a_o; nb += half_b_o; nd += done_o;
        end
        chk("R6 wrapped to base", addr_o, base);
        chk("R7 half A count", na, 2);
        chk("R7 half B count", nb, 2);
        chk("R6 no done in ring", nd, 0);
        chk("R6 still busy", busy_o, 1);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    // R8: stop against beat (line mode) and at a half boundary (ring)
    task automatic t_stop();
        do_reset();
        launch(50, 2, 2, 0, 1'b0, 1'b0);
        beat_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0; beat_i = 1'b0;
        chk("R8 stop clears busy", busy_o, 0);
        chk("R8 stop no done", done_o, 0);
        @(negedge clk);
        chk("R8 no late done", done_o, 0);
        launch(300, 0, 1, 3, 1'b0, 1'b0);
        for (int k = 0; k < 1; k++) begin
            beat_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0; beat_i = 1'b0;
        chk("R8 ring stop no half", {half_a_o, half_b_o}, 0);
        chk("R8 ring stop idle", busy_o, 0);
        stop_i = 1'b1; launch_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0; launch_i = 1'b0;
        chk("R8 stop beats launch", busy_o, 0);
    endtask

    // R9
    task automatic t_attr();
        do_reset();
        launch(10, 4, 4, 2, 1'b1, 1'b1);
        dir_i = 1'b0; burst_i = 1'b0;
        @(negedge clk);
        chk("R9 dir latched", dir_o, 1);
        chk("R9 burst latched", burst_o, 1);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        launch(10, 4, 4, 2, 1'b0, 1'b1);
        dir_i = 1'b1;
        @(negedge clk);
        chk("R9 dir dev-to-mem", dir_o, 0);
        chk("R9 burst again", burst_o, 1);
    endtask

    initial begin
        t_reset();
        t_lines();
        t_single();
        t_ring();
        t_stop();
        t_attr();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule